// File: doc/BRIEF.md
# SYSREF-Aligned Multiframe Clock Generator

This block keeps the local multiframe count for a serial converter link. The count runs in the link-clock domain, and the block raises a boundary tick each time the count passes through zero. The link sequencer uses that tick to time its state changes. A SYSREF signal enters the block already synchronized to the link clock. The block registers it and detects each 0-to-1 transition. An accepted transition reloads the counter with a programmable phase offset, so the local boundary lines up with a system-wide reference.

Two arming modes decide which transitions are accepted. In one-shot mode, a flag that comes out of reset set accepts the next transition and then clears itself. Software can re-arm it with a set pulse. In continuous mode, every transition is accepted. In continuous mode the block also checks that each SYSREF edge arrives where a whole number of multiframes would put it. When the edge is off that grid, the block pulses an error. A sticky "sampled" flag records that at least one transition was accepted, and the sequencer uses it to gate its exit from code-group synchronization. A reinit request clears that flag.

The multiframe length is configured as the product F×K minus one. F×K is always a multiple of 4, so the counter period is P = (F×K)/4 cycles.

Top module: `lmfc_gen`

## Requirements
- R1: While reset is held and on the first sample after it is released, the count is 0, the tick is 1, the one-shot flag is 1, the sampled flag is 0 and the period error is 0.
- R2: With no accepted edge, the count steps 0, 1, …, P-1, 0, … with P = (frame_mult_m1+1)/4. The tick is high exactly in the cycles where the count is 0.
- R3: A rising edge of sysref_in that is accepted loads the offset. The count equals the offset two rising clock edges after sysref_in is first sampled high, and then keeps counting from that value.
- R4: An offset greater than P-1 is replaced by 0 when it is loaded. P-1 itself loads unchanged.
- R5: With the one-shot flag set and continuous mode off, the first edge realigns the count and clears the flag in the same update. Later edges leave the count free-running.
- R6: A pulse on rearm_once sets the one-shot flag. When the pulse falls in the cycle where an edge is consumed, the realignment still happens and the flag stays set.
- R7: With continuous mode on, every rising edge realigns the count, whatever the state of the one-shot flag.
- R8: With the one-shot flag clear and continuous mode off, SYSREF edges have no effect on the count.
- R9: The sampled flag is set by the first accepted edge and cleared by reinit_req. When both happen in the same cycle, the accepted edge wins.
- R10: In continuous mode, an edge that arrives when the count is not at the position just before the reload value sets period_err. That position is the effective offset minus 1, modulo P. The pulse lasts one cycle and appears together with the reload. Edges on the grid give no error.
- R11: The first edge after continuous mode is switched on is never checked for period.
- R12: Holding sysref_in high causes only one reload. The count keeps running until the next 0-to-1 transition.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Link clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sysref_in | input | 1 | SYSREF, already synchronized to clk |
| frame_mult_m1 | input | FXK_W | F×K minus 1; the two low bits are expected to be 1 |
| phase_offset | input | OFF_W | Reload value applied on an accepted edge |
| always_realign | input | 1 | Continuous mode: accept every edge |
| rearm_once | input | 1 | One-cycle pulse that sets the one-shot flag |
| reinit_req | input | 1 | One-cycle pulse that clears the sampled flag |
| lmfc_tick | output | 1 | High when the count is 0 |
| lmfc_count | output | FXK_W-2 | Current multiframe count |
| sysref_seen | output | 1 | At least one edge accepted since reset or reinit |
| once_armed | output | 1 | One-shot flag |
| period_err | output | 1 | One-cycle pulse on an off-grid edge in continuous mode |

## Verification
Two events can land on the same update. An edge that consumes the one-shot flag can meet a re-arm pulse, and an accepted edge can meet a reinit request. Each collision is provoked by driving the control pulse in the single cycle in which the registered edge is being evaluated. It is judged by checking both the reloaded count and the flag two edges after SYSREF rises. For period checking, edges are placed both exactly a multiple of P cycles apart and deliberately off that grid. The bench then checks the error pulse and its one-cycle width, and separately checks that it stays silent on the first edge after continuous mode is enabled.

// File: rtl/lmfc_pkg.sv
package lmfc_pkg;

    // Registered SYSREF history used for edge detection.
    typedef struct packed {
        logic cur;
        logic prev;
    } sref_hist_t;

    // Arming / sampled flags kept in the top level.
    typedef struct packed {
        logic once;
        logic seen;
    } arm_state_t;

    // Period checker state.
    typedef struct packed {
        logic primed;
        logic err;
    } pchk_state_t;

    // Which mode admits an edge.
    typedef enum logic [1:0] {
        ACC_NONE   = 2'b00,
        ACC_ONCE   = 2'b01,
        ACC_ALWAYS = 2'b10,
        ACC_BOTH   = 2'b11
    } accept_mode_e;

endpackage

// File: rtl/sysref_edge_det.sv
module sysref_edge_det
    import lmfc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic sysref_i,
    output logic rise_o
);

    sref_hist_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.cur  = sysref_i;
        st_d.prev = st_q.cur;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rise_o = st_q.cur & ~st_q.prev;

    // R12: a rise is never reported in two consecutive cycles
    a_r12_single_rise: assert property (@(posedge clk) disable iff (!rst_n)
        rise_o |=> !rise_o);

endmodule

// File: rtl/lmfc_counter.sv
module lmfc_counter #(
    parameter int CNT_W = 8,
    parameter int OFF_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] last_i,
    input  logic             load_i,
    input  logic [OFF_W-1:0] offset_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic             tick_o,
    output logic [CNT_W-1:0] wrap_pos_o
);

    localparam int CMP_W = (CNT_W > OFF_W) ? CNT_W : OFF_W;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } cnt_state_t;

    cnt_state_t       st_d, st_q;
    logic [CMP_W-1:0] off_x;
    logic [CMP_W-1:0] last_x;
    logic             off_legal;
    logic [CNT_W-1:0] eff_off;

    always_comb begin
        off_x     = CMP_W'(offset_i);
        last_x    = CMP_W'(last_i);
        off_legal = (off_x <= last_x);
        eff_off   = off_legal ? off_x[CNT_W-1:0] : '0;
        wrap_pos_o = (eff_off == '0) ? last_i : (eff_off - 1'b1);

        st_d = st_q;
        if (load_i) begin
            st_d.cnt = eff_off;
        end else if (st_q.cnt >= last_i) begin
            st_d.cnt = '0;
        end else begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cnt_o  = st_q.cnt;
    assign tick_o = (st_q.cnt == '0);

    // R3 / R4: a load lands a legal value no greater than the last position
    a_r4_load_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        (load_i && $stable(last_i)) |=> (cnt_o <= last_i));

    // R2: the last position wraps to zero when nothing is loaded
    a_r2_wrap_to_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_i && cnt_o == last_i) |=> (cnt_o == '0));

    // R8: without a load the count advances by exactly one below the end
    a_r8_free_step: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_i && cnt_o < last_i && $stable(last_i)) |=> (cnt_o == $past(cnt_o) + 1'b1));

endmodule

// File: rtl/sysref_period_chk.sv
module sysref_period_chk
    import lmfc_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rise_i,
    input  logic             always_i,
    input  logic [CNT_W-1:0] cnt_i,
    input  logic [CNT_W-1:0] wrap_pos_i,
    output logic             err_o
);

    pchk_state_t st_d, st_q;
    logic        off_grid;

    always_comb begin
        off_grid = (cnt_i != wrap_pos_i);
        st_d     = st_q;
        st_d.err = rise_i & always_i & st_q.primed & off_grid;
        if (!always_i) begin
            st_d.primed = 1'b0;
        end else if (rise_i) begin
            st_d.primed = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign err_o = st_q.err;

    // R10: the error is a single-cycle pulse
    a_r10_err_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |=> !err_o);

    // R10: an error only follows an edge seen in continuous mode
    a_r10_err_cause: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |-> ($past(rise_i) && $past(always_i)));

    // R11: an edge taken while unprimed never raises the error
    a_r11_first_skip: assert property (@(posedge clk) disable iff (!rst_n)
        (rise_i && !st_q.primed) |=> !err_o);

endmodule

// File: rtl/lmfc_gen.sv
module lmfc_gen
    import lmfc_pkg::*;
#(
    parameter int FXK_W = 10,
    parameter int OFF_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sysref_in,
    input  logic [FXK_W-1:0] frame_mult_m1,
    input  logic [OFF_W-1:0] phase_offset,
    input  logic             always_realign,
    input  logic             rearm_once,
    input  logic             reinit_req,
    output logic             lmfc_tick,
    output logic [FXK_W-3:0] lmfc_count,
    output logic             sysref_seen,
    output logic             once_armed,
    output logic             period_err
);

    localparam int CNT_W = FXK_W - 2;

    logic             rise;
    logic             accept;
    accept_mode_e     mode;
    logic [CNT_W-1:0] last_pos;
    logic [CNT_W-1:0] wrap_pos;
    arm_state_t       st_d, st_q;

    sysref_edge_det i_edge (
        .clk      (clk),
        .rst_n    (rst_n),
        .sysref_i (sysref_in),
        .rise_o   (rise)
    );

    // (F*K - 1) >> 2 equals P - 1 because F*K is a multiple of four
    assign last_pos = frame_mult_m1[FXK_W-1:2];

    always_comb begin
        mode   = accept_mode_e'({always_realign, st_q.once});
        accept = rise && (mode != ACC_NONE);

        st_d = st_q;
        if (rearm_once) begin
            st_d.once = 1'b1;
        end else if (accept && st_q.once) begin
            st_d.once = 1'b0;
        end
        if (accept) begin
            st_d.seen = 1'b1;
        end else if (reinit_req) begin
            st_d.seen = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '{once: 1'b1, seen: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    lmfc_counter #(
        .CNT_W (CNT_W),
        .OFF_W (OFF_W)
    ) i_cnt (
        .clk        (clk),
        .rst_n      (rst_n),
        .last_i     (last_pos),
        .load_i     (accept),
        .offset_i   (phase_offset),
        .cnt_o      (lmfc_count),
        .tick_o     (lmfc_tick),
        .wrap_pos_o (wrap_pos)
    );

    sysref_period_chk #(
        .CNT_W (CNT_W)
    ) i_pchk (
        .clk        (clk),
        .rst_n      (rst_n),
        .rise_i     (rise),
        .always_i   (always_realign),
        .cnt_i      (lmfc_count),
        .wrap_pos_i (wrap_pos),
        .err_o      (period_err)
    );

    assign sysref_seen = st_q.seen;
    assign once_armed  = st_q.once;

    // R5: the one-shot flag only drops on an accepted edge
    a_r5_once_clear: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(once_armed) |-> $past(accept));

    // R6: a rearm pulse always leaves the flag set
    a_r6_rearm_wins: assert property (@(posedge clk) disable iff (!rst_n)
        rearm_once |=> once_armed);

    // R9: the sampled flag only rises on an accepted edge
    a_r9_seen_rise: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sysref_seen) |-> $past(accept));

    // R9: reinit without an accepted edge clears the flag
    a_r9_reinit_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (reinit_req && !accept) |=> !sysref_seen);

endmodule

// File: tb/test_lmfc_gen.sv
module test_lmfc_gen;

    localparam int CLK_PERIOD = 10;
    localparam int FXK_W = 10;
    localparam int OFF_W = 8;
    localparam int CNT_W = FXK_W - 2;

    logic             clk = 1'b0;
    logic             rst_n;
    logic             sysref_in;
    logic [FXK_W-1:0] frame_mult_m1;
    logic [OFF_W-1:0] phase_offset;
    logic             always_realign;
    logic             rearm_once;
    logic             reinit_req;
    logic             lmfc_tick;
    logic [CNT_W-1:0] lmfc_count;
    logic             sysref_seen;
    logic             once_armed;
    logic             period_err;

    int n_vec = 0;
    int n_bad = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    lmfc_gen #(.FXK_W(FXK_W), .OFF_W(OFF_W)) i_lmfc_gen (
        .clk            (clk),
        .rst_n          (rst_n),
        .sysref_in      (sysref_in),
        .frame_mult_m1  (frame_mult_m1),
        .phase_offset   (phase_offset),
        .always_realign (always_realign),
        .rearm_once     (rearm_once),
        .reinit_req     (reinit_req),
        .lmfc_tick      (lmfc_tick),
        .lmfc_count     (lmfc_count),
        .sysref_seen    (sysref_seen),
        .once_armed     (once_armed),
        .period_err     (period_err)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_vec++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_reset(input int fxk_m1, input int off);
        @(negedge clk);
        rst_n = 1'b0;
        sysref_in = 1'b0;
        frame_mult_m1 = FXK_W'(fxk_m1);
        phase_offset = OFF_W'(off);
        always_realign = 1'b0;
        rearm_once = 1'b0;
        reinit_req = 1'b0;
        step(3);
        rst_n = 1'b1;
    endtask

    // drives one-cycle SYSREF pulse; returns at the next negedge (edge cycle)
    task automatic pulse_sref();
        sysref_in = 1'b1;
        step(1);
        sysref_in = 1'b0;
    endtask

    task automatic t_reset_and_freerun();
        do_reset(15, 0); // P = 4
        chk("R1 count", lmfc_count, 0);
        chk("R1 tick", lmfc_tick, 1);
        chk("R1 once", once_armed, 1);
        chk("R1 seen", sysref_seen, 0);
        chk("R1 err", period_err, 0);
        for (int k = 1; k <= 9; k++) begin
            step(1);
            chk("R2 count", lmfc_count, k % 4);
            chk("R2 tick", lmfc_tick, (k % 4) == 0);
        end
    endtask

    task automatic t_once_and_ignore();
        int v;
        do_reset(39, 7); // P = 10
        step(4);
        pulse_sref();
        step(1);
        chk("R3 load offset", lmfc_count, 7);
        chk("R5 once cleared", once_armed, 0);
        chk("R9 seen set", sysref_seen, 1);
        step(3);
        chk("R3 continues", lmfc_count, 0);
        v = lmfc_count;
        pulse_sref();
        step(1);
        chk("R5 second edge ignored", lmfc_count, (v + 2) % 10);
        chk("R8 no mode count", lmfc_count, 2);
        reinit_req = 1'b1;
        step(1);
        reinit_req = 1'b0;
        step(1);
        chk("R9 reinit clears", sysref_seen, 0);
        v = lmfc_count;
        pulse_sref();
        step(1);
        chk("R8 edge no effect", lmfc_count, (v + 2) % 10);
        chk("R8 seen stays clear", sysref_seen, 0);
    endtask

    task automatic t_offset_range();
        do_reset(39, 12); // P = 10, offset out of range
        step(2);
        pulse_sref();
        step(1);
        chk("R4 illegal offset loads 0", lmfc_count, 0);
        rearm_once = 1'b1;
        step(1);
        rearm_once = 1'b0;
        chk("R6 rearm sets once", once_armed, 1);
        phase_offset = 8'd9;
        step(1);
        pulse_sref();
        step(1);
        chk("R4 P-1 loads unchanged", lmfc_count, 9);
    endtask

    task automatic t_collisions();
        do_reset(39, 5);
        step(3);
        sysref_in = 1'b1;
        step(1);
        sysref_in = 1'b0;
        rearm_once = 1'b1;   // lands in the edge cycle
        step(1);
        rearm_once = 1'b0;
        chk("R6 coincident realign", lmfc_count, 5);
        chk("R6 coincident flag kept", once_armed, 1);
        phase_offset = 8'd2;
        step(2);
        sysref_in = 1'b1;
        step(1);
        sysref_in = 1'b0;
        reinit_req = 1'b1;   // lands in the edge cycle
        step(1);
        reinit_req = 1'b0;
        chk("R9 accept beats reinit", sysref_seen, 1);
        chk("R9 realigned", lmfc_count, 2);
        chk("R5 once consumed", once_armed, 0);
    endtask

    task automatic t_always_and_period();
        do_reset(39, 3); // P = 10
        always_realign = 1'b1;
        step(5);
        pulse_sref();          // first edge: never checked
        step(1);
        chk("R11 first edge unchecked", period_err, 0);
        chk("R7 load", lmfc_count, 3);
        chk("R7 once consumed", once_armed, 0);
        step(8);
        pulse_sref();          // 10 cycles after previous rise
        step(1);
        chk("R10 on-grid no error", period_err, 0);
        chk("R7 realigned", lmfc_count, 3);
        step(18);
        pulse_sref();          // 20 cycles later: on grid
        step(1);
        chk("R10 two periods no error", period_err, 0);
        step(5);
        pulse_sref();          // 7 cycles later: off grid
        step(1);
        chk("R10 off-grid error", period_err, 1);
        chk("R7 realigned after error", lmfc_count, 3);
        step(1);
        chk("R10 error one cycle", period_err, 0);
        always_realign = 1'b0;
        step(2);
        always_realign = 1'b1;
        step(1);
        pulse_sref();          // first edge after re-enable, off grid
        step(1);
        chk("R11 re-enable skip", period_err, 0);
        chk("R7 load after re-enable", lmfc_count, 3);
        sysref_in = 1'b1;      // held high
        step(2);
        chk("R12 level load", lmfc_count, 3);
        step(3);
        chk("R12 no reload while high", lmfc_count, 6);
        chk("R12 no error while high", period_err, 0);
        sysref_in = 1'b0;
    endtask

    initial begin
        rst_n = 1'b0;
        t_reset_and_freerun();
        t_once_and_ignore();
        t_offset_range();
        t_collisions();
        t_always_and_period();
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 20000);
        n_vec++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule